// File: doc/BRIEF.md
# Auto-Reload Down-Counting Interval Timer

This block is a programmable interval timer that sits on a simple synchronous register port. It holds a 32-bit counter that runs downward from a software-chosen start value. The counter is clocked through a gate and a power-of-two prescaler. Each time the counter is found at zero on a prescaled tick, the block emits a single-cycle interrupt pulse. It then either reloads the start value and keeps going, or stops and clears its own start bit (one-shot use).

Software brings the timer up in three writes. The first write to the control word sets only the clock gate and the prescale field. The second write puts the period into the load word. The third write to the control word sets the gate, the repeat bit and the start bit together. Elapsed ticks since the last reload can be found by subtracting the live count from the programmed period. The prescaler never passes the input clock through undivided: its smallest ratio is two.

A small state machine in the counter core has two states. **STOPPED** is entered at reset, when software clears start, and on one-shot expiry. **COUNTING** is entered from STOPPED when start and the clock gate are both set, and on that transition the load value is copied into the counter. The transitions are named *arm* (STOPPED to COUNTING), *halt* (COUNTING to STOPPED because start was cleared) and *expire* (COUNTING to STOPPED at zero with repeat clear). In COUNTING, *wrap* reloads at zero with repeat set, and *step* decrements on every other tick.

Top module: `tick_timer`

## Requirements
- R1: The control word is at byte offset 0x0 and is read/write. Bit 0 is start, bit 1 is repeat (auto-reload), bits 4:2 are the prescale field P, bit 5 is the clock gate and bit 6 is a stored spare bit with no effect. It reads back exactly the written value of bits 6:0, and all other bits read as zero.
- R2: The load word at offset 0x4 is write-only and always reads as zero. The count word at offset 0x8 is read-only: writes to it leave the count unchanged.
- R3: After reset the control word, the count and the interrupt output are all zero.
- R4: When start and the clock gate are set while STOPPED, the load value appears in the count one clock after the edge that wrote start.
- R5: While COUNTING with the gate set, the count decrements once every 2^(P+1) input clocks. The first decrement comes 2^(P+1) clocks after the copy of R4, and the count never changes on two consecutive clocks.
- R6: A tick that finds the count at zero raises the interrupt output for exactly one clock. With repeat set, the same edge reloads the load value, so interrupts repeat every (N+1)·2^(P+1) clocks for a load value N.
- R7: With repeat clear, a tick at zero raises the interrupt once. The count then stays at zero, the start bit reads back as zero and no further interrupts occur.
- R8: A load write while COUNTING does not alter the live count. The new value is used at the next reload.
- R9: With the clock gate clear, the count holds whatever start holds, and the prescaler is cleared. After the gate is set again, the first decrement comes 2^(P+1) clocks after the enabling write edge.
- R10: Clearing start while COUNTING stops the timer with the count held at its present value.
- R11: A load value of 0xFFFFFFFF counts the full 32-bit range, decrementing from 0xFFFFFFFF on each tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-clock interrupt pulse on count expiry |

## Verification
The counter is run from random load values (0 to 11), prescale settings (0 to 2) and repeat/one-shot choices. Each clock is compared against a closed-form model of count and interrupt. This separates period errors (N versus N+1 ticks), divider errors (2^P versus 2^(P+1)) and reload-versus-stop behaviour. Directed runs cover cases that random draws rarely reach: the widest divider, the full-range load, gating during a run (which shows whether the prescaler restarts), halting and re-arming (which shows whether the load is copied), and a load rewrite mid-run (which shows whether only the reload value changes).

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // prescale field width; the divider ratio spans 2 .. 2^(2^PTV_W)
    localparam int PTV_W = 3;
    localparam int PRE_W = 1 << PTV_W;

    // control word bit positions
    localparam int CB_START  = 0;
    localparam int CB_REPEAT = 1;
    localparam int CB_PTV    = 2;
    localparam int CB_GATE   = CB_PTV + PTV_W;
    localparam int CB_SPARE  = CB_GATE + 1;
    localparam int CTRL_W    = CB_SPARE + 1;

    // word indices (byte offset / 4)
    localparam logic [1:0] IDX_CTRL  = 2'd0;
    localparam logic [1:0] IDX_LOAD  = 2'd1;
    localparam logic [1:0] IDX_COUNT = 2'd2;

    typedef enum logic [0:0] {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             start_clr,
    input  logic [DW-1:0]    count_i,
    output logic             start_o,
    output logic             repeat_o,
    output logic [PTV_W-1:0] ptv_o,
    output logic             gate_o,
    output logic [DW-1:0]    load_o
);

    localparam int IDX_LSB = 2;

    logic [1:0]       word_idx;
    logic             spare_q;
    logic [CTRL_W-1:0] ctrl_view;
    logic             unused_addr_bits;

    assign word_idx         = bus_addr[IDX_LSB +: 2];
    assign unused_addr_bits = ^{bus_addr[IDX_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            repeat_o <= 1'b0;
            ptv_o    <= '0;
            gate_o   <= 1'b0;
            spare_q  <= 1'b0;
        end else if (bus_we && word_idx == IDX_CTRL) begin
            start_o  <= bus_wdata[CB_START];
            repeat_o <= bus_wdata[CB_REPEAT];
            ptv_o    <= bus_wdata[CB_PTV +: PTV_W];
            gate_o   <= bus_wdata[CB_GATE];
            spare_q  <= bus_wdata[CB_SPARE];
        end else if (start_clr) begin
            start_o  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_o <= '0;
        end else if (bus_we && word_idx == IDX_LOAD) begin
            load_o <= bus_wdata;
        end
    end

    always_comb begin
        ctrl_view            = '0;
        ctrl_view[CB_START]  = start_o;
        ctrl_view[CB_REPEAT] = repeat_o;
        ctrl_view[CB_PTV +: PTV_W] = ptv_o;
        ctrl_view[CB_GATE]   = gate_o;
        ctrl_view[CB_SPARE]  = spare_q;
    end

    always_comb begin
        unique case (word_idx)
            IDX_CTRL:  bus_rdata = DW'(ctrl_view);
            IDX_COUNT: bus_rdata = count_i;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_presc.sv
module tick_timer_presc
    import tick_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick,
    output logic [PRE_W-1:0] cnt_o
);

    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    // ratio is 2^(ptv+1); the smallest setting still halves the clock
    assign span  = (PRE_W+1)'(1) << ((PTV_W+1)'(ptv) + (PTV_W+1)'(1));
    assign limit = PRE_W'(span - 1'b1);
    assign tick  = run && (cnt_o == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (!run || tick) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          gate,
    input  logic          rep,
    input  logic [CW-1:0] load,
    input  logic          tick,
    output logic [CW-1:0] count_o,
    output logic          running,
    output logic          start_clr,
    output logic          irq_o
);

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] count_d;
    logic          irq_d;
    logic          at_zero;

    assign at_zero = (count_o == '0);
    assign running = (state_q == ST_COUNTING);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath decisions
    always_comb begin
        state_d   = state_q;
        count_d   = count_o;
        irq_d     = 1'b0;
        start_clr = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                if (start && gate) begin          // arm
                    count_d = load;
                    state_d = ST_COUNTING;
                end
            end
            ST_COUNTING: begin
                if (!start) begin                 // halt
                    state_d = ST_STOPPED;
                end else if (tick) begin
                    if (at_zero) begin
                        irq_d = 1'b1;
                        if (rep) begin            // wrap
                            count_d = load;
                        end else begin            // expire
                            start_clr = 1'b1;
                            state_d   = ST_STOPPED;
                        end
                    end else begin                // step
                        count_d = count_o - 1'b1;
                    end
                end
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            count_o <= count_d;
            irq_o   <= irq_d;
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_pulse
);

    logic             ctrl_start;
    logic             ctrl_reload;
    logic [PTV_W-1:0] ctrl_ptv;
    logic             ctrl_en;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count_q;
    logic             start_clr;
    logic             running;
    logic             tick;
    logic [PRE_W-1:0] presc_cnt;
    logic             presc_run;

    assign presc_run = running && ctrl_en;

    tick_timer_regs #(
        .DW (CNT_W),
        .AW (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .start_clr (start_clr),
        .count_i   (count_q),
        .start_o   (ctrl_start),
        .repeat_o  (ctrl_reload),
        .ptv_o     (ctrl_ptv),
        .gate_o    (ctrl_en),
        .load_o    (load_q)
    );

    tick_timer_presc u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (presc_run),
        .ptv   (ctrl_ptv),
        .tick  (tick),
        .cnt_o (presc_cnt)
    );

    tick_timer_core #(
        .CW (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ctrl_start),
        .gate      (ctrl_en),
        .rep       (ctrl_reload),
        .load      (load_q),
        .tick      (tick),
        .count_o   (count_q),
        .running   (running),
        .start_clr (start_clr),
        .irq_o     (irq_pulse)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CW = 32,
    parameter int AW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [CW-1:0]    bus_rdata,
    input logic             irq,
    input logic [CW-1:0]    count,
    input logic             en,
    input logic             start,
    input logic             reload,
    input logic             running,
    input logic             tick,
    input logic [PRE_W-1:0] presc_cnt
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);  // R6

    AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(count) == '0);  // R6

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && $past(tick) && $past(start) && $past(count) != '0)
        |-> count == $past(count) - 1'b1);  // R5

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && running && count != $past(count)) |=> $stable(count));  // R5

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> $stable(count));  // R9

    AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> presc_cnt == '0);  // R9

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(reload) && !$past(bus_we)) |-> (!start && !running));  // R7

    AST_LOAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:2] == IDX_LOAD) |-> bus_rdata == '0);  // R2

endmodule

bind tick_timer tick_timer_chk #(
    .CW (CNT_W),
    .AW (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq_pulse),
    .count     (count_q),
    .en        (ctrl_en),
    .start     (ctrl_start),
    .reload    (ctrl_reload),
    .running   (running),
    .tick      (tick),
    .presc_cnt (presc_cnt)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

    localparam logic [31:0] F_START = 32'h01;
    localparam logic [31:0] F_REP   = 32'h02;
    localparam logic [31:0] F_GATE  = 32'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h8;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tick_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // model: count after k edges following the start write
    function automatic logic [31:0] exp_count(longint n, int d, bit rep, int k);
        longint m = longint'((k - 1) / d);
        if (rep) return 32'(n - (m % (n + 1)));
        return (m > n) ? 32'd0 : 32'(n - m);
    endfunction

    function automatic bit exp_irq(longint n, int d, bit rep, int k);
        longint m = longint'((k - 1) / d);
        if (k < 1 || ((k - 1) % d) != 0 || m == 0) return 1'b0;
        if (rep) return (m % (n + 1)) == 0;
        return m == n + 1;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 4'h8;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 4'h8;
        #1;
    endtask

    task automatic arm(input logic [31:0] n, input int ptv, input bit rep);
        logic [31:0] base;
        base = F_GATE | (32'(ptv) << 2) | (rep ? F_REP : 32'd0);
        wr(4'h0, 32'd0);
        wr(4'h0, base);
        wr(4'h4, n);
        wr(4'h0, base | F_START);
    endtask

    task automatic trace(input logic [31:0] n, input int ptv, input bit rep, input int cycles);
        int d;
        d = 1 << (ptv + 1);
        arm(n, ptv, rep);
        for (int k = 1; k <= cycles; k++) begin
            @(negedge clk);
            #1;
            check(bus_rdata == exp_count(longint'(n), d, rep, k), "R5/R6/R11 count", bus_rdata, exp_count(longint'(n), d, rep, k));
            check(irq_pulse == exp_irq(longint'(n), d, rep, k), "R6/R7 irq", 32'(irq_pulse), 32'(exp_irq(longint'(n), d, rep, k)));
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, c0;
        bit seen;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        rd(4'h0, v); check(v == 32'd0, "R3 ctrl", v, 32'd0);
        rd(4'h8, v); check(v == 32'd0, "R3 count", v, 32'd0);
        check(irq_pulse == 1'b0, "R3 irq", 32'(irq_pulse), 32'd0);

        // R1 control layout and readback
        wr(4'h0, 32'hFFFF_FF5C);
        rd(4'h0, v); check(v == 32'h5C, "R1 ctrl readback", v, 32'h5C);
        wr(4'h0, 32'h22);
        rd(4'h0, v); check(v == 32'h22, "R1 ctrl readback2", v, 32'h22);

        // R2 load reads zero, count ignores writes
        wr(4'h4, 32'h1234_5678);
        rd(4'h4, v); check(v == 32'd0, "R2 load read", v, 32'd0);
        wr(4'h8, 32'hDEAD_BEEF);
        repeat (3) @(negedge clk);
        rd(4'h8, v); check(v == 32'd0, "R2 count write ignored", v, 32'd0);

        // random trials
        for (int t = 0; t < 25; t++) begin
            int n, p, cyc;
            bit r;
            n = int'($urandom % 12);
            p = int'($urandom % 3);
            r = 1'($urandom % 2);
            cyc = (n + 2) * (1 << (p + 1)) * 2 + 3;
            trace(32'(n), p, r, cyc);
        end

        // R5 widest divider
        trace(32'd1, 7, 1'b1, 1 + 256 * 4 + 2);

        // R11 full range
        trace(32'hFFFF_FFFF, 0, 1'b1, 40);

        // R7 one-shot leaves start clear
        arm(32'd2, 0, 1'b0);
        repeat (20) @(negedge clk);
        rd(4'h0, v); check(v == F_GATE, "R7 start cleared", v, F_GATE);
        rd(4'h8, v); check(v == 32'd0, "R7 count held", v, 32'd0);

        // R9 gate freeze and prescaler restart
        arm(32'd100, 0, 1'b1);
        repeat (21) @(negedge clk);
        wr(4'h0, F_REP | F_START);
        rd(4'h8, c0);
        repeat (30) @(negedge clk);
        rd(4'h8, v); check(v == c0, "R9 frozen", v, c0);
        wr(4'h0, F_GATE | F_REP | F_START);
        @(negedge clk); #1;
        check(bus_rdata == c0, "R9 resume hold", bus_rdata, c0);
        @(negedge clk); #1;
        check(bus_rdata == c0 - 1, "R9 first tick", bus_rdata, c0 - 1);

        // R10 halt holds count
        wr(4'h0, F_GATE | F_REP);
        rd(4'h8, c0);
        repeat (10) @(negedge clk);
        rd(4'h8, v); check(v == c0, "R10 halt hold", v, c0);

        // R4 re-arm copies new load
        wr(4'h4, 32'd7);
        wr(4'h0, F_GATE | F_REP | F_START);
        @(negedge clk); #1;
        check(bus_rdata == 32'd7, "R4 load copy", bus_rdata, 32'd7);

        // R8 load write while counting only changes reload value
        wr(4'h4, 32'd3);
        #1;
        check(bus_rdata <= 32'd7 && bus_rdata != 32'd3, "R8 live count kept", bus_rdata, 32'd7);
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk); #1;
            if (irq_pulse) begin
                seen = 1'b1;
                check(bus_rdata == 32'd3, "R8 reload new value", bus_rdata, 32'd3);
            end
        end
        check(seen, "R8 irq seen", 32'(seen), 32'd1);
        repeat (7) @(negedge clk);
        check(irq_pulse == 1'b0, "R6 no early irq", 32'(irq_pulse), 32'd0);
        @(negedge clk);
        check(irq_pulse == 1'b1, "R6 period N+1", 32'(irq_pulse), 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule